// File: doc/BRIEF.md
# Transmit Bit Monitor for a Dominant-Wins Serial Bus

This block sits between a frame transmitter and the line driver of a node on a wired serial bus. On that bus a logical 0 is dominant: any node driving 0 forces the whole line to 0, and a logical 1 (recessive) appears only when every node leaves the line alone. The block decides the level the node drives in each bit period. At each sample point it compares that level with the level read back from the line.

During the identifier and request fields, reading dominant while driving recessive means another node has won the bus. The block drops to receive-only and reports the loss without treating it as an error. In any other field, a disagreement between the driven and read levels is reported as a bit error. The block also enforces the bit-stuffing rule. While transmitting, after five equal bus bits it inserts one bit of opposite polarity and tells the frame source to hold its data bit. While listening, it flags a sixth equal bit as a stuff violation.

After an arbitration loss or a bit error, the node keeps its driver recessive. It waits until the line has shown six consecutive recessive sample points before a new transmission may start. Frame assembly and CRC work belong to the transmitter upstream.

Top module: `can_tx_bit_monitor`

## Requirements
- R1: A synchronous active-high reset returns the block to idle: the driven bit is 1 (recessive), and the stuff request, hold and all three pulse outputs are 0.
- R2: While the transmit request is high and the block is transmitting, the driven bit equals the transmit bit. 0 is dominant and the bus reads as the AND of all drivers. When not transmitting, the driven bit is 1.
- R3: On a sample strobe in the arbitration field, if a data bit (not a stuff bit) drives 1 and reads 0, the block raises the arbitration-lost output for exactly one cycle after that strobe edge, raises no bit error, and drives 1 from then on.
- R4: On a sample strobe while transmitting, a disagreement between driven and read levels raises a one-cycle bit error pulse and ends the transmission. This covers a disagreement outside the arbitration field, a disagreement on an inserted stuff bit, and driving 0 while reading 1.
- R5: While transmitting inside the stuff zone, once five consecutive bus samples have the same polarity, the stuff request is high for the next bit period. During that period the driven bit is the opposite polarity and the transmit bit is ignored.
- R6: The equal-polarity count restarts at 1 on every polarity change and on every inserted stuff bit. The stuff bit itself is the first bit of the new run.
- R7: When not transmitting, inside the stuff zone, a sixth consecutive bus sample of the same polarity raises a one-cycle stuff error pulse, and the count restarts at 1.
- R8: After an arbitration loss or bit error, the hold output stays high and the transmit request is ignored (the driven bit stays 1) until six consecutive strobed bus samples read 1. A sample reading 0 restarts that count. The hold falls at the edge of the sixth sample.
- R9: Clock cycles without a sample strobe raise no pulse and do not change the hold state, whatever the bus and transmit levels.
- R10: Outside the stuff zone, the equal-polarity count is cleared and no stuff bit is requested, however long a run of equal bits lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_stb_i | input | 1 | One-cycle strobe at the sample point of each bit |
| tx_req_i | input | 1 | Frame transmitter wants the bus (held for the frame) |
| tx_bit_i | input | 1 | Next data bit from the frame transmitter |
| rx_bit_i | input | 1 | Bus level read back from the line |
| arb_field_i | input | 1 | Current bit belongs to the identifier/request field |
| stuff_zone_i | input | 1 | Current bit lies in the region covered by bit stuffing |
| bus_drive_o | output | 1 | Level driven onto the line (1 = recessive) |
| stuff_req_o | output | 1 | Current bit period carries an inserted stuff bit; hold the data bit |
| arb_lost_o | output | 1 | One-cycle pulse: bus lost to another node |
| bit_err_o | output | 1 | One-cycle pulse: driven and read levels disagree |
| stuff_err_o | output | 1 | One-cycle pulse: six equal bits seen while listening |
| hold_o | output | 1 | Retry holdoff in progress; transmit request ignored |

## Verification
The hardest condition to reach from the ports is a disagreement on an inserted stuff bit inside the arbitration field. This must count as a bit error and not as an arbitration loss. Reaching it takes five equal transmitted bits in the arbitration field so that the block itself inserts a recessive stuff bit. The bench's second bus node then pulls that one bit dominant. The retry holdoff is driven with a dominant sample in the middle of the recessive run, so that the restart of the six-sample count is observed on the hold output while the transmit request stays high.

// File: rtl/can_mon_pkg.sv
package can_mon_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TX   = 2'd1,
      ST_WAIT = 2'd2
   } mon_state_e;
endpackage

// File: rtl/can_stuff_track.sv
module can_stuff_track #(
   parameter int LIMIT = 5
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic stb_i,
   input  logic zone_i,
   input  logic rx_i,
   input  logic tx_mode_i,
   input  logic abort_i,
   output logic pend_o,
   output logic last_o,
   output logic viol_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          last_q;
   logic          pend_q;
   logic          same_c;
   logic          at_max_c;

   initial begin
      if (LIMIT < 2) $fatal(1, "LIMIT must be at least 2");
   end

   assign same_c   = (cnt_q != '0) && (rx_i == last_q);
   assign at_max_c = (cnt_q == CNT_MAX);
   assign viol_o   = stb_i && zone_i && !tx_mode_i && !pend_q && same_c && at_max_c;
   assign pend_o   = pend_q;
   assign last_o   = last_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         last_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         if (stb_i) begin
            if (!zone_i) begin
               cnt_q  <= '0;
               pend_q <= 1'b0;
            end else if (pend_q && tx_mode_i) begin
               // R6: the inserted bit opens a new run
               cnt_q  <= CNT_ONE;
               last_q <= rx_i;
               pend_q <= 1'b0;
            end else if (same_c) begin
               if (at_max_c) begin
                  cnt_q <= CNT_ONE;
               end else begin
                  cnt_q  <= cnt_q + CNT_ONE;
                  pend_q <= tx_mode_i && !abort_i && ((cnt_q + CNT_ONE) == CNT_MAX);
               end
            end else begin
               cnt_q  <= CNT_ONE;
               last_q <= rx_i;
               pend_q <= 1'b0;
            end
         end
         if (!tx_mode_i) pend_q <= 1'b0;
      end
   end

   // R5
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= CNT_MAX);

   // R5
   pend_tx_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pend_q |-> $past(tx_mode_i));

   // R10
   zone_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (stb_i && !zone_i) |=> (cnt_q == '0) && !pend_q);
endmodule

// File: rtl/can_gap_timer.sv
module can_gap_timer #(
   parameter int GAP = 6
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic stb_i,
   input  logic run_i,
   input  logic start_i,
   input  logic rx_i,
   output logic done_o
);
   localparam int GW = $clog2(GAP + 1);
   localparam logic [GW-1:0] LAST_CNT = GW'(GAP - 1);

   logic [GW-1:0] cnt_q;

   initial begin
      if (GAP < 2) $fatal(1, "GAP must be at least 2");
   end

   assign done_o = stb_i && run_i && rx_i && (cnt_q == LAST_CNT);

   always_ff @(posedge clk_i) begin
      if (rst_i || start_i) begin
         cnt_q <= '0;
      end else if (stb_i && run_i) begin
         if (!rx_i || done_o) cnt_q <= '0;
         else                 cnt_q <= cnt_q + GW'(1);
      end
   end

   // R8
   gap_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST_CNT);

   // R8
   gap_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (stb_i && run_i && !rx_i && !start_i) |=> (cnt_q == '0));
endmodule

// File: rtl/can_bit_cmp.sv
module can_bit_cmp #(
   parameter bit FLAG_DOM_LOSS = 1'b1
) (
   input  logic drive_i,
   input  logic rx_i,
   input  logic arb_i,
   input  logic stuff_bit_i,
   output logic arb_loss_o,
   output logic bit_err_o
);
   logic mism_c;
   logic overridden_c;

   assign overridden_c = drive_i && !rx_i;

   generate
      if (FLAG_DOM_LOSS) begin : g_both_ways
         assign mism_c = drive_i ^ rx_i;
      end else begin : g_rec_only
         assign mism_c = overridden_c;
      end
   endgenerate

   assign arb_loss_o = overridden_c && arb_i && !stuff_bit_i;
   assign bit_err_o  = mism_c && !arb_loss_o;
endmodule

// File: rtl/can_tx_bit_monitor.sv
module can_tx_bit_monitor
   import can_mon_pkg::*;
#(
   parameter int STUFF_LIMIT   = 5,
   parameter int RETRY_GAP     = 6,
   parameter bit FLAG_DOM_LOSS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic sample_stb_i,
   input  logic tx_req_i,
   input  logic tx_bit_i,
   input  logic rx_bit_i,
   input  logic arb_field_i,
   input  logic stuff_zone_i,
   output logic bus_drive_o,
   output logic stuff_req_o,
   output logic arb_lost_o,
   output logic bit_err_o,
   output logic stuff_err_o,
   output logic hold_o
);
   mon_state_e state_q, state_d;
   logic tx_mode_c;
   logic pend_c, last_c, viol_c;
   logic arb_loss_c, bit_err_c, abort_c;
   logic gap_done_c, enter_wait_c;
   logic arb_lost_q, bit_err_q, stuff_err_q;

   assign tx_mode_c   = (state_q == ST_TX) && tx_req_i;
   assign bus_drive_o = tx_mode_c ? (pend_c ? !last_c : tx_bit_i) : 1'b1;

   can_bit_cmp #(.FLAG_DOM_LOSS(FLAG_DOM_LOSS)) u_cmp (
      .drive_i     (bus_drive_o),
      .rx_i        (rx_bit_i),
      .arb_i       (arb_field_i),
      .stuff_bit_i (pend_c),
      .arb_loss_o  (arb_loss_c),
      .bit_err_o   (bit_err_c)
   );

   assign abort_c      = sample_stb_i && tx_mode_c && (arb_loss_c || bit_err_c);
   assign enter_wait_c = abort_c;

   can_stuff_track #(.LIMIT(STUFF_LIMIT)) u_stuff (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .stb_i     (sample_stb_i),
      .zone_i    (stuff_zone_i),
      .rx_i      (rx_bit_i),
      .tx_mode_i (tx_mode_c),
      .abort_i   (abort_c),
      .pend_o    (pend_c),
      .last_o    (last_c),
      .viol_o    (viol_c)
   );

   can_gap_timer #(.GAP(RETRY_GAP)) u_gap (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .stb_i   (sample_stb_i),
      .run_i   (state_q == ST_WAIT),
      .start_i (enter_wait_c),
      .rx_i    (rx_bit_i),
      .done_o  (gap_done_c)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (tx_req_i) state_d = ST_TX;
         ST_TX: begin
            if (!tx_req_i)    state_d = ST_IDLE;
            else if (abort_c) state_d = ST_WAIT;
         end
         ST_WAIT: if (gap_done_c) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q     <= ST_IDLE;
         arb_lost_q  <= 1'b0;
         bit_err_q   <= 1'b0;
         stuff_err_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         arb_lost_q  <= sample_stb_i && tx_mode_c && arb_loss_c;
         bit_err_q   <= sample_stb_i && tx_mode_c && bit_err_c;
         stuff_err_q <= viol_c;
      end
   end

   assign stuff_req_o = pend_c;
   assign arb_lost_o  = arb_lost_q;
   assign bit_err_o   = bit_err_q;
   assign stuff_err_o = stuff_err_q;
   assign hold_o      = (state_q == ST_WAIT);

   // R1
   rst_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (bus_drive_o && !hold_o && !stuff_req_o));

   // R3
   arb_to_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      arb_lost_o |-> (hold_o && !bit_err_o));

   // R4
   err_from_tx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      bit_err_o |-> ($past(state_q) == ST_TX) && hold_o);

   // R8
   hold_drive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_o |-> bus_drive_o);

   // R9
   no_stb_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(sample_stb_i) |-> !(arb_lost_o || bit_err_o || stuff_err_o));

   // R9
   hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (hold_o && !sample_stb_i) |=> hold_o);
endmodule

// File: tb/can_tx_bit_monitor_test.sv
`timescale 1ns/100ps
module can_tx_bit_monitor_test;
   localparam int L = 5;
   localparam int G = 6;

   typedef struct packed {
      logic drv;
      logic arb;
      logic be;
      logic se;
      logic sreq;
      logic hold;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic stb = 1'b0, req = 1'b0, txb = 1'b1, oth = 1'b1;
   logic arb = 1'b0, zone = 1'b0, frc = 1'b0, fval = 1'b1;
   logic rx_bit;
   logic bus_drive, stuff_req, arb_lost, bit_err, stuff_err, hold;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   exp_t  exp_q[$];
   string tag_q[$];

   // model state: 0 idle, 1 transmitting, 2 holdoff
   int m_st = 0, m_cnt = 0, m_gap = 0;
   bit m_last = 1'b1, m_pend = 1'b0;

   always #2.5 clk = ~clk;

   assign rx_bit = frc ? fval : (bus_drive & oth);

   can_tx_bit_monitor uut (
      .clk_i        (clk),
      .rst_i        (rst),
      .sample_stb_i (stb),
      .tx_req_i     (req),
      .tx_bit_i     (txb),
      .rx_bit_i     (rx_bit),
      .arb_field_i  (arb),
      .stuff_zone_i (zone),
      .bus_drive_o  (bus_drive),
      .stuff_req_o  (stuff_req),
      .arb_lost_o   (arb_lost),
      .bit_err_o    (bit_err),
      .stuff_err_o  (stuff_err),
      .hold_o       (hold)
   );

   task automatic model_step(output exp_t e);
      bit txm, drv, rx, mism, al, be, se;
      txm = (m_st == 1) && req;
      drv = txm ? (m_pend ? !m_last : txb) : 1'b1;
      rx  = frc ? fval : (drv & oth);
      mism = drv ^ rx;
      al = 1'b0; be = 1'b0; se = 1'b0;
      if (stb && txm && mism) begin
         if (arb && !m_pend && drv && !rx) al = 1'b1;
         else be = 1'b1;
      end
      if (stb) begin
         if (!zone) begin
            m_cnt = 0; m_pend = 1'b0;
         end else if (m_pend && txm) begin
            m_cnt = 1; m_last = rx; m_pend = 1'b0;
         end else if (m_cnt != 0 && rx == m_last) begin
            if (m_cnt == L) begin
               se = !txm; m_cnt = 1;
            end else begin
               m_cnt = m_cnt + 1;
               m_pend = txm && !(al || be) && (m_cnt == L);
            end
         end else begin
            m_cnt = 1; m_last = rx; m_pend = 1'b0;
         end
      end
      if (!txm) m_pend = 1'b0;
      case (m_st)
         0: if (req) m_st = 1;
         1: begin
            if (!req) m_st = 0;
            else if (al || be) begin m_st = 2; m_gap = 0; end
         end
         default: if (stb) begin
            if (!rx) m_gap = 0;
            else if (m_gap == G - 1) begin m_st = 0; m_gap = 0; end
            else m_gap = m_gap + 1;
         end
      endcase
      e.drv = drv; e.arb = al; e.be = be; e.se = se;
      e.sreq = m_pend; e.hold = (m_st == 2);
   endtask

   task automatic drv_clk(input logic s, r, t, o, a, z, f, fv, input string tag);
      exp_t e;
      stb = s; req = r; txb = t; oth = o; arb = a; zone = z; frc = f; fval = fv;
      model_step(e);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic bitc(input logic r, t, o, a, z, input string tag);
      drv_clk(1'b1, r, t, o, a, z, 1'b0, 1'b1, tag);
      drv_clk(1'b0, r, t, o, a, z, 1'b0, 1'b1, tag);
   endtask

   task automatic bitf(input logic r, t, fv, a, z, input string tag);
      drv_clk(1'b1, r, t, 1'b1, a, z, 1'b1, fv, tag);
      drv_clk(1'b0, r, t, 1'b1, a, z, 1'b0, 1'b1, tag);
   endtask

   task automatic direct(input logic got, input logic want, input string tag);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, want);
      end
   endtask

   // monitor: pops one expected item per clock edge
   always @(posedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         exp_t  a;
         string tg;
         a.drv = bus_drive;
         #1;
         e  = exp_q.pop_front();
         tg = tag_q.pop_front();
         a.arb = arb_lost; a.be = bit_err; a.se = stuff_err;
         a.sreq = stuff_req; a.hold = hold;
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s: got drv=%b arb=%b berr=%b serr=%b sreq=%b hold=%b expected drv=%b arb=%b berr=%b serr=%b sreq=%b hold=%b",
                     tg, a.drv, a.arb, a.be, a.se, a.sreq, a.hold,
                     e.drv, e.arb, e.be, e.se, e.sreq, e.hold);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      direct(bus_drive, 1'b1, "R1 drive");
      direct(hold, 1'b0, "R1 hold");
      direct(stuff_req, 1'b0, "R1 stuff_req");
      direct(arb_lost | bit_err | stuff_err, 1'b0, "R1 pulses");

      // R2 R5 R6: transmit with stuffing
      drv_clk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2 enter");
      for (int i = 0; i < 5; i++) bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5 zeros");
      bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5 stuff recessive");
      for (int i = 0; i < 4; i++) bitc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R6 run after stuff");
      bitc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R6 stuff dominant");
      bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 change");
      bitc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R2 data one");
      bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2 data zero");
      // R10: no stuffing outside the zone
      for (int i = 0; i < 7; i++) bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 long run");
      drv_clk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 leave");

      // R3 R8: lose arbitration, then holdoff with a restart
      drv_clk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R3 enter");
      bitc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R3 id0");
      bitc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R3 id1");
      bitc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R3 lost");
      for (int i = 0; i < 3; i++) bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 gap part");
      bitc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 gap restart");
      for (int i = 0; i < 6; i++) bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 gap full");
      bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 retry");
      drv_clk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 leave");

      // R4: recessive overridden outside arbitration
      drv_clk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 enter");
      bitc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 data mismatch");
      for (int i = 0; i < 6; i++) bitc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 recover");
      drv_clk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 leave");

      // R4: dominant driven, recessive read
      drv_clk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 enter2");
      bitf(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 dominant lost");
      for (int i = 0; i < 6; i++) bitc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 recover2");
      drv_clk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 leave2");

      // R4: stuff bit overridden inside arbitration is a bit error
      drv_clk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 enter3");
      for (int i = 0; i < 5; i++) bitc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5 arb zeros");
      bitc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4 stuff bit overridden");
      for (int i = 0; i < 6; i++) bitc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 recover3");
      drv_clk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 leave3");

      // R7: stuff violation while listening
      for (int i = 0; i < 6; i++) bitc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 six zeros");
      for (int i = 0; i < 5; i++) bitc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R7 five ones");
      bitc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 legal change");
      bitc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 leave zone");

      // R9: no strobe, no reaction
      drv_clk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9 enter");
      for (int i = 0; i < 4; i++) drv_clk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 idle clocks");
      drv_clk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9 leave");

      stb = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule